// File: doc/BRIEF.md
# Disturbance Frame Filter for a Contactless Receive Path

This block sits between the byte-level receive decoder and the receive FIFO. It forwards received bytes to the FIFO as they arrive. It also decides whether a frame is a real card response or an artefact of electromagnetic disturbance. A frame counts as disturbance when it goes wrong before its first few bytes (three by default) have been accepted, or when it ends before reaching that length. Such a frame is discarded without any report: the FIFO is told to flush back to the frame's start, the receive-complete interrupt stays low, and the filter waits for the next start-of-frame.

With the suppression enable low, the block passes every frame through unchanged. Errors are then reported at end of frame together with the interrupt. A sticky flag shows that at least one frame was discarded. It stays set until a clear strobe arrives.

Top module: `emd_frame_filter`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `fifoWr`, `fifoFlush`, `rxIrq`, `rxErr` and `emdDropped` are all 0.
- R2: A `byteValid` inside an open frame produces a one-cycle `fifoWr` on the next cycle, with `fifoData` equal to that byte. The byte in the same cycle as a drop decision is not written.
- R3: `sofIn` opens a frame with a byte count of zero and a clean error flag. `sofIn` inside an open frame restarts the frame. In a `sofIn` cycle, every other receive strobe is ignored.
- R4: With `suppressEn`=1, an `errIn` or `collIn` while fewer than GUARD_BYTES (default 3) bytes have been accepted earlier in the frame gives a one-cycle `fifoFlush` on the next cycle, closes the frame, and raises neither `rxIrq` nor `rxErr`. A collision is handled exactly like an error.
- R5: With `suppressEn`=1, an `eofIn` is a drop if the accepted bytes, counting a byte in the same cycle, number fewer than GUARD_BYTES. The drop gives the same `fifoFlush` with no `rxIrq`.
- R6: An `eofIn` that is not dropped closes the frame and gives a one-cycle `rxIrq` on the next cycle.
- R7: An error or collision that is not dropped marks the frame without a flush. `rxErr` is raised for one cycle, together with the frame's `rxIrq`.
- R8: With `suppressEn`=0, `fifoFlush` never rises, and every frame that ends gives `rxIrq`, whatever its length or errors.
- R9: `emdDropped` rises on the cycle after any drop and holds until a `stickyClr` cycle. A drop in the same cycle as `stickyClr` leaves it set.
- R10: Outside an open frame, including after a drop, `byteValid`, `errIn`, `collIn` and `eofIn` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| suppressEn | input | 1 | Enables disturbance filtering |
| sofIn | input | 1 | Start-of-frame strobe from the decoder |
| byteValid | input | 1 | Received byte strobe |
| byteData | input | DATA_W | Received byte |
| errIn | input | 1 | Decoder error strobe |
| collIn | input | 1 | Collision strobe |
| eofIn | input | 1 | End-of-frame strobe |
| stickyClr | input | 1 | Clears the drop flag |
| fifoWr | output | 1 | FIFO write strobe |
| fifoData | output | DATA_W | FIFO write data |
| fifoFlush | output | 1 | Rewind the FIFO to the frame start |
| rxIrq | output | 1 | Receive-complete interrupt pulse |
| rxErr | output | 1 | Frame error status, valid with rxIrq |
| emdDropped | output | 1 | Sticky: a disturbance frame was dropped |

## Verification
A wrong byte count or frame-open state shows at the ports within one cycle of the next error or end-of-frame strobe. It appears as a flush where an interrupt belongs, or the reverse. A frame error flag that leaks from one frame to the next would show as a spurious `rxErr` on the following frame's interrupt. A bench model that tracks frame state on its own compares every output on every clock, so such faults are reported on the cycle they first reach a pin.

// File: rtl/emd_filter_pkg.sv
package emd_filter_pkg;

  // Strobes the control decides on each cycle, registered by the datapath.
  typedef struct packed {
    logic wr;
    logic flush;
    logic irq;
    logic err;
    logic drop;
  } ctrlStrobes_t;

endpackage

// File: rtl/emd_filter_ctrl.sv
module emd_filter_ctrl
  import emd_filter_pkg::*;
#(
  parameter int GUARD_BYTES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         suppressEn,
  input  logic         sofIn,
  input  logic         byteValid,
  input  logic         errIn,
  input  logic         collIn,
  input  logic         eofIn,
  output ctrlStrobes_t strobes
);

  localparam int CNT_W = $clog2(GUARD_BYTES + 1) + 1;
  localparam logic [CNT_W-1:0] GUARD_LIM = CNT_W'(GUARD_BYTES);

  logic             inFrame, inFrameNext;
  logic [CNT_W-1:0] byteCnt, byteCntNext;
  logic             frameErr, frameErrNext;
  logic             anyErr;
  logic [CNT_W-1:0] cntWithByte;
  logic             guardOpen;

  assign anyErr      = errIn | collIn;
  assign guardOpen   = byteCnt < GUARD_LIM;
  // the counter saturates at the guard limit; beyond it only ">= limit" matters
  assign cntWithByte = (byteValid && guardOpen) ? byteCnt + 1'b1 : byteCnt;

  always_comb begin
    strobes      = '0;
    inFrameNext  = inFrame;
    byteCntNext  = byteCnt;
    frameErrNext = frameErr;
    if (sofIn) begin
      inFrameNext  = 1'b1;
      byteCntNext  = '0;
      frameErrNext = 1'b0;
    end else if (inFrame) begin
      if (anyErr && suppressEn && guardOpen) begin
        strobes.flush = 1'b1;
        strobes.drop  = 1'b1;
        inFrameNext   = 1'b0;
      end else begin
        strobes.wr   = byteValid;
        byteCntNext  = cntWithByte;
        frameErrNext = frameErr | anyErr;
        if (eofIn) begin
          inFrameNext = 1'b0;
          if (suppressEn && (cntWithByte < GUARD_LIM)) begin
            strobes.wr    = 1'b0;
            strobes.flush = 1'b1;
            strobes.drop  = 1'b1;
          end else begin
            strobes.irq = 1'b1;
            strobes.err = frameErr | anyErr;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame  <= 1'b0;
      byteCnt  <= '0;
      frameErr <= 1'b0;
    end else begin
      inFrame  <= inFrameNext;
      byteCnt  <= byteCntNext;
      frameErr <= frameErrNext;
    end
  end

  // R8: no flush is ever requested while suppression is off
  a_r8_no_flush_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !suppressEn |-> !strobes.flush);

  // R10: a closed frame with no start strobe produces nothing
  a_r10_idle_silent: assert property (@(posedge clk) disable iff (!rstN)
    (!inFrame && !sofIn) |-> (strobes == '0));

  // R4: a drop always closes the frame
  a_r4_drop_closes: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drop |=> !inFrame || $past(sofIn));

  // R3: a start strobe leaves a fresh, open frame
  a_r3_sof_fresh: assert property (@(posedge clk) disable iff (!rstN)
    sofIn |=> (inFrame && byteCnt == '0 && !frameErr));

endmodule

// File: rtl/emd_filter_datapath.sv
module emd_filter_datapath
  import emd_filter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] byteData,
  input  logic              stickyClr,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoFlush,
  output logic              rxIrq,
  output logic              rxErr,
  output logic              emdDropped
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fifoWr     <= 1'b0;
      fifoData   <= '0;
      fifoFlush  <= 1'b0;
      rxIrq      <= 1'b0;
      rxErr      <= 1'b0;
      emdDropped <= 1'b0;
    end else begin
      fifoWr    <= strobes.wr;
      fifoFlush <= strobes.flush;
      rxIrq     <= strobes.irq;
      rxErr     <= strobes.err;
      if (strobes.wr) fifoData <= byteData;
      if (strobes.drop)   emdDropped <= 1'b1;
      else if (stickyClr) emdDropped <= 1'b0;
    end
  end

  // R4: a flush and a completion interrupt never coincide
  a_r4_flush_excludes_irq: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFlush && rxIrq));

  // R7: error status only accompanies the interrupt
  a_r7_err_with_irq: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> rxIrq);

  // R9: the sticky flag only falls on a clear without a drop
  a_r9_sticky_hold: assert property (@(posedge clk) disable iff (!rstN)
    (emdDropped && !stickyClr) |=> emdDropped);

  // R9: every flush leaves the sticky flag set
  a_r9_flush_sets_sticky: assert property (@(posedge clk) disable iff (!rstN)
    fifoFlush |-> emdDropped);

endmodule

// File: rtl/emd_frame_filter.sv
module emd_frame_filter
  import emd_filter_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GUARD_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              suppressEn,
  input  logic              sofIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              errIn,
  input  logic              collIn,
  input  logic              eofIn,
  input  logic              stickyClr,
  output logic              fifoWr,
  output logic [DATA_W-1:0] fifoData,
  output logic              fifoFlush,
  output logic              rxIrq,
  output logic              rxErr,
  output logic              emdDropped
);

  ctrlStrobes_t strobes;

  emd_filter_ctrl #(.GUARD_BYTES(GUARD_BYTES)) ctrl_i (
    .clk(clk), .rstN(rstN), .suppressEn(suppressEn), .sofIn(sofIn),
    .byteValid(byteValid), .errIn(errIn), .collIn(collIn), .eofIn(eofIn),
    .strobes(strobes)
  );

  emd_filter_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteData(byteData),
    .stickyClr(stickyClr), .fifoWr(fifoWr), .fifoData(fifoData),
    .fifoFlush(fifoFlush), .rxIrq(rxIrq), .rxErr(rxErr),
    .emdDropped(emdDropped)
  );

  // R6: the completion interrupt is a single-cycle pulse
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |=> !rxIrq);

endmodule

// File: tb/emd_frame_filter_tb.sv
module emd_frame_filter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD = 3;

  logic clk = 0, rstN = 0;
  logic suppressEn = 0, sofIn = 0, byteValid = 0, errIn = 0, collIn = 0;
  logic eofIn = 0, stickyClr = 0;
  logic [7:0] byteData = 0;
  logic fifoWr, fifoFlush, rxIrq, rxErr, emdDropped;
  logic [7:0] fifoData;

  int vectors = 0, fails = 0;

  // reference model state
  bit mOpen, mErr, eWr, eFl, eIrq, eErr, eSticky;
  int mCnt;
  bit [7:0] eData;

  always #(CLK_PERIOD/2) clk = ~clk;

  emd_frame_filter dut_i (
    .clk(clk), .rstN(rstN), .suppressEn(suppressEn), .sofIn(sofIn),
    .byteValid(byteValid), .byteData(byteData), .errIn(errIn),
    .collIn(collIn), .eofIn(eofIn), .stickyClr(stickyClr),
    .fifoWr(fifoWr), .fifoData(fifoData), .fifoFlush(fifoFlush),
    .rxIrq(rxIrq), .rxErr(rxErr), .emdDropped(emdDropped)
  );

  always @(posedge clk) begin
    bit dropIt;
    dropIt = 0;
    eWr = 0; eFl = 0; eIrq = 0; eErr = 0;
    if (!rstN) begin
      mOpen = 0; mErr = 0; mCnt = 0; eSticky = 0; eData = 0;
    end else begin
      if (sofIn) begin
        mOpen = 1; mErr = 0; mCnt = 0;
      end else if (mOpen) begin
        if ((errIn || collIn) && suppressEn && mCnt < GUARD) begin
          dropIt = 1; mOpen = 0;
        end else begin
          if (byteValid) begin eWr = 1; eData = byteData; mCnt++; end
          if (errIn || collIn) mErr = 1;
          if (eofIn) begin
            mOpen = 0;
            if (suppressEn && mCnt < GUARD) begin
              dropIt = 1;
              if (eWr) begin eWr = 0; end
            end else begin
              eIrq = 1; eErr = mErr;
            end
          end
        end
      end
      if (dropIt) begin eFl = 1; eSticky = 1; end
      else if (stickyClr) eSticky = 0;
    end
  end

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp(rstN ? "R2" : "R1", "fifoWr", fifoWr, eWr);
    if (eWr) cmp("R2", "fifoData", fifoData, eData);
    cmp(rstN ? "R4/R5" : "R1", "fifoFlush", fifoFlush, eFl);
    cmp(rstN ? "R6" : "R1", "rxIrq", rxIrq, eIrq);
    cmp(rstN ? "R7" : "R1", "rxErr", rxErr, eErr);
    cmp(rstN ? "R9" : "R1", "emdDropped", emdDropped, eSticky);
  end

  task automatic step(input bit s, input bit bv, input bit [7:0] d,
                      input bit e, input bit c, input bit f, input bit clr);
    @(posedge clk); #1;
    sofIn = s; byteValid = bv; byteData = d; errIn = e; collIn = c;
    eofIn = f; stickyClr = clr;
  endtask
  task automatic sof();               step(1, 0, 0, 0, 0, 0, 0); endtask
  task automatic rxb(input bit [7:0] d); step(0, 1, d, 0, 0, 0, 0); endtask
  task automatic err();               step(0, 0, 0, 1, 0, 0, 0); endtask
  task automatic coll();              step(0, 0, 0, 0, 1, 0, 0); endtask
  task automatic eof();               step(0, 0, 0, 0, 0, 1, 0); endtask
  task automatic idle();              step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic clr();               step(0, 0, 0, 0, 0, 0, 1); endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);               // R1 reset state compared each cycle
    #1 rstN = 1; suppressEn = 1;
    idle(); idle();
    // R4: error after two bytes -> drop
    sof(); rxb(8'h11); rxb(8'h22); err(); idle();
    // R10: activity after a drop is ignored
    rxb(8'h33); err(); eof(); idle();
    // R4: collision treated as error
    sof(); rxb(8'h44); coll(); idle();
    // R9: clear the sticky flag
    clr(); idle();
    // R5: empty frame and two-byte frame dropped at end
    sof(); eof(); idle();
    sof(); rxb(8'h55); rxb(8'h66); eof(); idle();
    // R5: third byte arriving with eof counts -> passes (R6)
    sof(); rxb(8'h01); rxb(8'h02); step(0, 1, 8'h03, 0, 0, 1, 0); idle();
    // R6/R7: full frame, error after guard bytes
    clr();
    sof(); rxb(8'hA1); rxb(8'hA2); rxb(8'hA3); rxb(8'hA4); err(); rxb(8'hA5); eof(); idle();
    // R7: next frame must not inherit the error
    sof(); rxb(8'hB1); rxb(8'hB2); rxb(8'hB3); eof(); idle();
    // R3: restart mid-frame, sof with other strobes ignored
    sof(); rxb(8'hC1); rxb(8'hC2); step(1, 1, 8'hEE, 1, 0, 1, 0);
    rxb(8'hC3); rxb(8'hC4); rxb(8'hC5); eof(); idle();
    // R9: drop and clear in the same cycle keeps the flag
    sof(); step(0, 0, 0, 1, 0, 0, 1); idle(); clr(); idle();
    // R8: suppression off -> everything passes
    suppressEn = 0;
    sof(); rxb(8'hD1); err(); eof(); idle();
    sof(); eof(); idle();
    sof(); coll(); rxb(8'hD2); eof(); idle();
    suppressEn = 1;
    // R2: byte written in same cycle as late error is kept
    sof(); rxb(8'hE1); rxb(8'hE2); rxb(8'hE3); step(0, 1, 8'hE4, 1, 0, 0, 0); eof(); idle();
    idle(); idle();
    @(negedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule